// File: doc/BRIEF.md
# Start-Stop Bit Clock and Word Strobe Generator

This block sits behind an FSK demodulator and turns its asynchronous character stream (one start bit, eight data bits sent least significant first, one stop bit) into a gated bit clock and an end-of-word strobe. A plain external shift register can then capture each byte without any UART logic. The bit clock idles high. For every character it gives exactly eight low-going pulses, and each rising edge falls at the middle of a data bit. The stop and start bits get no pulses. After the last rising edge an active-low ready strobe is asserted for one bit time.

All timing comes from a fixed division of the master clock. A half bit lasts `HALF_CYC` master cycles; the default of 1488 gives a bit period of 2976 master cycles. The block never resynchronises to individual bits and never measures the baud rate. A qualified falling edge on the serial line starts a burst. The line counts as high (idle) whenever carrier is absent. A power-down input forces both outputs inactive at once and clears the sequencer.

Top module: `frame_clock_gen`

## Requirements
- R1: After reset, `bit_clk_o` and `ready_n_o` are both 1 and the block waits for a start edge.
- R2: A burst starts on the first rising master clock edge that samples `ser_in` = 0 when the previous sample was `ser_in` = 1 taken with `carrier_on` = 1 and `pwr_down` = 0. Call that edge E0.
- R3: `bit_clk_o` goes low 2·H cycles after E0 (H = `HALF_CYC`). Each pulse is H cycles low followed by H cycles high, and there are exactly `PULSES` (8) pulses, so the last rising edge is at E0 + 17·H.
- R4: With data at the nominal rate (one bit per 2·H cycles starting at E0), the value of `ser_in` at each rising edge of `bit_clk_o` is, in order, data bit 0 through data bit 7.
- R5: `ready_n_o` goes to 0 on the edge where the last pulse rises, stays 0 for 2·H cycles, and returns to 1 at E0 + 19·H.
- R6: Falling edges of `ser_in` between E0 and the end of the ready strobe start nothing. Once the strobe ends, the block is armed again, so a character whose start bit immediately follows the previous stop bit is handled.
- R7: While `carrier_on` = 0, `ser_in` is treated as high and no burst can start. If carrier comes up while `ser_in` is already low, this does not count as a start edge.
- R8: If `carrier_on` falls during a burst, the burst stops at the next clock edge. `bit_clk_o` stays 1 and no ready strobe is given for that character.
- R9: While `pwr_down` = 1, both outputs are 1 from the same cycle on, an active burst is cancelled, and no burst starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_in | input | 1 | Demodulated serial data, 1 = mark |
| carrier_on | input | 1 | 1 while carrier is present |
| pwr_down | input | 1 | 1 forces the block idle with outputs inactive |
| bit_clk_o | output | 1 | Gated bit clock, idles high, eight low pulses per character |
| ready_n_o | output | 1 | Active-low end-of-word strobe |

## Verification
The bench counts in master cycles from E0, the edge that samples the start bit. It expects `bit_clk_o` to be low in half-bit slots 2, 4, …, 16 and `ready_n_o` to be low from 17·H up to 19·H. Inputs change and outputs are sampled on the falling clock edge. A sample taken k falling edges after the start bit was driven therefore shows the state after k−1 edges past E0, and the bench computes its expected value from that offset. For aborts, the output is expected to be released at the first sample after the edge that sees the lost carrier. Power-down acts combinationally, so the outputs are expected to read high at the very next sample. The data bit captured on each observed rising edge is compared with the byte that was sent.

// File: rtl/frame_clock_gen.sv
module frame_clock_gen #(
  parameter int HALF_CYC = 1488,
  parameter int PULSES   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_in,
  input  logic carrier_on,
  input  logic pwr_down,
  output logic bit_clk_o,
  output logic ready_n_o
);

  localparam int LAST_HALF = 2 * PULSES;
  localparam int DR_CYC    = 2 * HALF_CYC;
  localparam int CW        = $clog2(DR_CYC + 1);
  localparam int IW        = $clog2(LAST_HALF + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_READY} seq_t;

  seq_t          state;
  logic [CW-1:0] hcnt;
  logic [IW-1:0] hidx;
  logic          hi_q;

  wire live     = carrier_on & ~pwr_down;
  wire start    = hi_q & ~ser_in;
  wire half_end = (hcnt == CW'(HALF_CYC - 1));
  wire dr_end   = (hcnt == CW'(DR_CYC - 1));
  wire clk_low  = (state == S_RUN) && (hidx >= IW'(2)) && !hidx[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      hcnt  <= '0;
      hidx  <= '0;
      hi_q  <= 1'b0;
    end else begin
      hi_q <= live & ser_in;
      if (!live) begin
        state <= S_IDLE;
        hcnt  <= '0;
        hidx  <= '0;
      end else begin
        case (state)
          S_IDLE: if (start) begin
            state <= S_RUN;
            hcnt  <= '0;
            hidx  <= '0;
          end
          S_RUN: begin
            if (half_end) begin
              hcnt <= '0;
              if (hidx == IW'(LAST_HALF)) begin
                state <= S_READY;
                hidx  <= '0;
              end else begin
                hidx <= hidx + IW'(1);
              end
            end else begin
              hcnt <= hcnt + CW'(1);
            end
          end
          S_READY: begin
            if (dr_end) begin
              state <= S_IDLE;
              hcnt  <= '0;
            end else begin
              hcnt <= hcnt + CW'(1);
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assign bit_clk_o = pwr_down | ~clk_low;
  assign ready_n_o = pwr_down | (state != S_READY);

  a_r9_pd_clears: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> (state == S_IDLE));

  a_r8_carrier_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (!carrier_on && state == S_RUN) |=> (state == S_IDLE && ready_n_o));

  a_r5_ready_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_down && $fell(ready_n_o)) |-> $rose(bit_clk_o));

  a_r3_pulse_only_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_clk_o |-> (state == S_RUN && hidx <= IW'(LAST_HALF)));

  a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN && live && !(half_end && hidx == IW'(LAST_HALF)))
      |=> (state == S_RUN && $stable(hidx) || hidx == $past(hidx) + IW'(1)));

  a_r2_idle_start_only_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !(live && start)) |=> (state == S_IDLE));

endmodule

// File: tb/sim_frame_clock_gen.sv
module sim_frame_clock_gen;
  localparam int H = 6;
  localparam int P = 8;
  localparam int WIN = 20 * H;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_in = 1'b1;
  logic carrier_on = 1'b1;
  logic pwr_down = 1'b0;
  logic bit_clk_o, ready_n_o;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  frame_clock_gen #(.HALF_CYC(H), .PULSES(P)) u0 (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .carrier_on(carrier_on),
    .pwr_down(pwr_down), .bit_clk_o(bit_clk_o), .ready_n_o(ready_n_o));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic exp_clk(input int m);
    int h = m / H;
    return !(h >= 2 && h <= 2 * P && h % 2 == 0);
  endfunction

  function automatic logic exp_rdy(input int m);
    return !(m >= 17 * H && m < 19 * H);
  endfunction

  function automatic logic frame_bit(input logic [7:0] b, input int k);
    int i = k / (2 * H);
    if (i == 0) return 1'b0;
    if (i <= 8) return b[i-1];
    return 1'b1;
  endfunction

  // cut_kind: 0 none, 1 carrier loss, 2 power-down, applied after sample cut_k
  task automatic run_char(input logic [7:0] b, input int cut_k, input int cut_kind,
                          input string req);
    logic prev_clk = 1'b1;
    logic [7:0] cap = '0;
    int rises = 0;
    int ready_lows = 0;
    int bad = 0;
    int bad_k = 0, bad_act = 0, bad_exp = 0;
    for (int k = 0; k < WIN; k++) begin
      @(negedge clk);
      if (k >= 1) begin
        logic ec, er;
        ec = exp_clk(k - 1);
        er = exp_rdy(k - 1);
        if (cut_kind != 0 && k > cut_k) begin ec = 1'b1; er = 1'b1; end
        if (bit_clk_o !== ec || ready_n_o !== er) begin
          if (bad == 0) begin
            bad_k = k;
            bad_act = {bit_clk_o, ready_n_o};
            bad_exp = {ec, er};
          end
          bad++;
        end
        if (!prev_clk && bit_clk_o) begin
          rises++;
          cap = {ser_in, cap[7:1]};
        end
        if (!ready_n_o) ready_lows++;
        prev_clk = bit_clk_o;
      end
      ser_in = frame_bit(b, k);
      if (cut_kind == 1 && k == cut_k) carrier_on = 1'b0;
      if (cut_kind == 2 && k == cut_k) pwr_down = 1'b1;
    end
    if (bad != 0) $display("  %s first mismatch at sample %0d", req, bad_k);
    check(bad == 0, req, bad_act, bad_exp);
    if (cut_kind == 0) begin
      check(rises == P, "R3 pulse count", rises, P);
      check(cap == b, "R4 captured byte", cap, b);
      check(ready_lows == 2 * H, "R5 ready length", ready_lows, 2 * H);
    end else begin
      check(ready_lows == 0, "R8/R9 no ready after abort", ready_lows, 0);
      @(negedge clk);
      carrier_on = 1'b1;
      pwr_down = 1'b0;
      ser_in = 1'b1;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic quiet_window(input int n, input bit toggle, input string req);
    int bad = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (bit_clk_o !== 1'b1 || ready_n_o !== 1'b1) bad++;
      if (toggle) ser_in = k[1];
    end
    check(bad == 0, req, bad, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(bit_clk_o == 1'b1, "R1 bit clock after reset", bit_clk_o, 1);
    check(ready_n_o == 1'b1, "R1 ready after reset", ready_n_o, 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    quiet_window(10, 1'b0, "R1 idle after reset");
  endtask

  task automatic t_chars;
    run_char(8'hA5, 0, 0, "R2 R3 R5 waveform 0xA5");
    run_char(8'h55, 0, 0, "R6 waveform 0x55 back-to-back");
    run_char(8'h00, 0, 0, "R6 waveform 0x00");
    run_char(8'hFF, 0, 0, "R3 waveform 0xFF");
    repeat (5) @(negedge clk);
    run_char(8'h3C, 0, 0, "R2 waveform 0x3C after idle");
  endtask

  task automatic t_no_carrier;
    carrier_on = 1'b0;
    quiet_window(WIN, 1'b1, "R7 toggling line without carrier");
    ser_in = 1'b0;
    @(negedge clk);
    carrier_on = 1'b1;
    quiet_window(WIN, 1'b0, "R7 carrier up with line low");
    ser_in = 1'b1;
    repeat (3) @(negedge clk);
    run_char(8'h96, 0, 0, "R7 burst once line high with carrier");
  endtask

  task automatic t_aborts;
    run_char(8'h5A, 8 * H, 1, "R8 carrier loss mid-burst");
    run_char(8'hC3, 16 * H + 2, 1, "R8 carrier loss near last pulse");
    run_char(8'h81, 6 * H + 1, 2, "R9 power-down mid-burst");
    pwr_down = 1'b1;
    quiet_window(WIN, 1'b1, "R9 no burst while powered down");
    pwr_down = 1'b0;
    ser_in = 1'b1;
    repeat (3) @(negedge clk);
    run_char(8'h7E, 0, 0, "R9 normal burst after power-down");
  endtask

  initial begin
    t_reset();
    t_chars();
    t_no_carrier();
    t_aborts();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule